// File: doc/BRIEF.md
# Register File with Conditional Set-and-Branch

This block holds sixteen 32-bit general registers for a small processor core and folds in the evaluation of the conditional set-and-branch instruction. Two combinational read ports and one clocked write port serve the datapath. Entry 0 always reads zero and entry 1 always reads one. Entry 13 carries the flag bits and the ALU operation code, and its most significant bit is held at one. Entry 14 is the stack pointer and entry 15 is the program counter.

A set-and-branch request supplies a 4-bit condition, a destination select and a 16-bit offset. The condition is a mask over the three top flag bits plus one polarity bit. Because the top flag is always one, the same compare expresses "always", "never", and each flag-set or flag-clear test. When the request is valid, the destination register receives 1 if the condition holds and 0 if it does not. When it holds, the sign-extended offset is added to the program counter. Naming entry 0 or 1 as the destination gives a pure branch. A zero offset gives a pure conditional set.

The instruction is four bytes long. By the time the request is presented, entry 15 already points just past those four bytes, and the offset is relative to that value.

Top module: `regfile_sb`

## Requirements
- R1: Entry 0 reads 0x00000000 and entry 1 reads 0x00000001 on both read ports at all times. Writes to them, from the write port or as a set-and-branch destination, have no effect.
- R2: Bit 31 of entry 13 always reads 1. Bits 30:0 are writable. After reset, entry 13 reads 0x80000000.
- R3: While wr_en is high at a rising clock edge, wr_data is stored into the entry named by wr_sel. Both read ports show the new value from that edge onward.
- R4: The flag triple F is entry 13 bits [31:29]: bit 31 is always one, bit 30 is sign and bit 29 is zero. With sb_valid high, sb_taken is high exactly when (F & sb_cond[2:0]) equals ({3{sb_cond[3]}} & sb_cond[2:0]). So cond 4'b1100 is always true, and any code with bit 3 clear and bit 2 set is never true.
- R5: At a rising edge with sb_valid high, the entry named by sb_dest is written with 0x00000001 if the condition holds and with 0x00000000 otherwise.
- R6: sb_next_pc equals entry 15 plus the offset sign-extended to 32 bits when sb_taken is high. Otherwise it equals entry 15 unchanged. At the edge, entry 15 takes sb_next_pc.
- R7: With sb_dest set to 0 or 1, only the program counter changes. With a zero offset, the program counter keeps its value and only the destination changes.
- R8: When a set-and-branch and a port write land in the same edge, the set-and-branch update wins for entry 15 and for its own destination. A port write to any other entry still takes effect.
- R9: With sb_dest equal to 15, the program counter update wins over the 0/1 destination value.
- R10: With sb_valid low, sb_taken is low, sb_next_pc equals entry 15, and no set-and-branch state changes.
- R11: After reset, every entry other than 1 and 13 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 4 | Read port A entry select |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_sel | input | 4 | Read port B entry select |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 4 | Write port entry select |
| wr_data | input | 32 | Write port data |
| sb_valid | input | 1 | Set-and-branch request present this cycle |
| sb_cond | input | 4 | Condition: bit 3 polarity, bits 2:0 flag mask |
| sb_dest | input | 4 | Entry that receives the 0/1 result |
| sb_offset | input | 16 | Signed branch offset |
| sb_taken | output | 1 | Condition holds for a valid request |
| sb_next_pc | output | 32 | Program counter value after this request |

## Verification
The bench builds the block with its default parameters: 32-bit data, 16 entries and a 16-bit offset. This makes the whole condition space reachable. All 16 codes are driven against the four flag states the writable sign and zero bits allow, with the top flag pinned to one. The default offset width also puts the sign-extension boundary at a 16-bit value. Negative and maximum positive offsets therefore show whether the carry into the upper half of the program counter is correct.

// File: rtl/rfsb_pkg.sv
package rfsb_pkg;
    localparam int REG_ZERO  = 0;
    localparam int REG_ONE   = 1;
    localparam int REG_FLAGS = 13;
    localparam int REG_SP    = 14;
    localparam int REG_PC    = 15;
    localparam int FLAG_W    = 3;
    localparam int COND_W    = FLAG_W + 1;
endpackage

// File: rtl/rfsb_cond.sv
module rfsb_cond
    import rfsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [FLAG_W-1:0] flags,
    input  logic [COND_W-1:0] cond,
    output logic              taken
);
    logic [FLAG_W-1:0] mask;
    logic [FLAG_W-1:0] want;

    always_comb begin
        mask  = cond[FLAG_W-1:0];
        want  = {FLAG_W{cond[FLAG_W]}} & mask;
        taken = valid && ((flags & mask) == want);
    end

    // R4: polarity clear on the always-one flag never passes
    a_r4_never_true: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond[FLAG_W] && cond[FLAG_W-1]) |-> !taken);
    // R4: cond 4'b1100 always passes for a valid request
    a_r4_always_true: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cond == 4'b1100) |-> taken);
    // R10: no request, no taken
    a_r10_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !taken);
endmodule

// File: rtl/rfsb_pc_calc.sv
module rfsb_pc_calc #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [DATA_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic              taken,
    output logic [DATA_W-1:0] next_pc
);
    localparam int EXT_W = DATA_W - OFF_W;

    logic [DATA_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        next_pc = taken ? (pc + off_ext) : pc;
    end
endmodule

// File: rtl/rfsb_bank.sv
module rfsb_bank
    import rfsb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sb_we,
    input  logic [SEL_W-1:0]  sb_dest,
    input  logic [DATA_W-1:0] sb_val,
    input  logic              pc_we,
    input  logic [DATA_W-1:0] pc_next,
    output logic [FLAG_W-1:0] flags,
    output logic [DATA_W-1:0] pc_q
);
    localparam logic [DATA_W-1:0] FORCE_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == REG_ZERO) begin : g_zero
            assign view[i] = '0;
        end else if (i == REG_ONE) begin : g_one
            assign view[i] = DATA_W'(1);
        end else begin : g_store
            localparam logic [DATA_W-1:0] FORCE = (i == REG_FLAGS) ? FORCE_MASK : '0;
            logic [DATA_W-1:0] q;
            logic [DATA_W-1:0] d;

            always_comb begin
                d = q;
                if ((i == REG_PC) && pc_we)
                    d = pc_next;
                else if (sb_we && (sb_dest == SEL_W'(i)))
                    d = sb_val;
                else if (wr_en && (wr_sel == SEL_W'(i)))
                    d = wr_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= FORCE;
                else        q <= d | FORCE;
            end

            assign view[i] = q;
        end
    end

    assign rd_a_data = view[rd_a_sel];
    assign rd_b_data = view[rd_b_sel];
    assign flags     = view[REG_FLAGS][DATA_W-1 -: FLAG_W];
    assign pc_q      = view[REG_PC];

    // R2: top flag bit stays set
    a_r2_flag_forced: assert property (@(posedge clk) disable iff (!rst_n)
        view[REG_FLAGS][DATA_W-1]);
    // R8: program counter update beats the write port
    a_r8_pc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> pc_q == $past(pc_next));
    // R1: constant entries visible through read port A
    a_r1_const_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == SEL_W'(REG_ZERO)) |-> rd_a_data == '0);
    // R3: plain port write lands in an ordinary entry
    a_r3_port_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_W'(REG_ONE) && wr_sel < SEL_W'(REG_FLAGS)
         && !(sb_we && sb_dest == wr_sel))
        |=> view[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/regfile_sb.sv
module regfile_sb
    import rfsb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int OFF_W  = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sb_valid,
    input  logic [COND_W-1:0] sb_cond,
    input  logic [SEL_W-1:0]  sb_dest,
    input  logic [OFF_W-1:0]  sb_offset,
    output logic              sb_taken,
    output logic [DATA_W-1:0] sb_next_pc
);
    logic [FLAG_W-1:0] flags;
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] set_val;

    assign set_val = {{(DATA_W-1){1'b0}}, sb_taken};

    rfsb_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (sb_valid),
        .flags (flags),
        .cond  (sb_cond),
        .taken (sb_taken)
    );

    rfsb_pc_calc #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_pc (
        .pc      (pc_q),
        .offset  (sb_offset),
        .taken   (sb_taken),
        .next_pc (sb_next_pc)
    );

    rfsb_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_sel  (rd_a_sel),
        .rd_a_data (rd_a_data),
        .rd_b_sel  (rd_b_sel),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sb_we     (sb_valid),
        .sb_dest   (sb_dest),
        .sb_val    (set_val),
        .pc_we     (sb_valid),
        .pc_next   (sb_next_pc),
        .flags     (flags),
        .pc_q      (pc_q)
    );

    // R6: taken request moves PC by the sign-extended offset
    a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        sb_taken |=> pc_q == $past(pc_q) + {{(DATA_W-OFF_W){$past(sb_offset[OFF_W-1])}}, $past(sb_offset)});
    // R10: PC holds when nothing targets it
    a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sb_valid && !(wr_en && wr_sel == SEL_W'(REG_PC))) |=> $stable(pc_q));
endmodule

// File: tb/regfile_sb_bench.sv
module regfile_sb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0, sb_dest = '0, sb_cond = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sb_next_pc;
    logic        wr_en = 1'b0, sb_valid = 1'b0, sb_taken;
    logic [15:0] sb_offset = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    regfile_sb u_regfile_sb (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sb_valid(sb_valid), .sb_cond(sb_cond), .sb_dest(sb_dest),
        .sb_offset(sb_offset), .sb_taken(sb_taken), .sb_next_pc(sb_next_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input int sel, input logic [31:0] exp);
        rd_a_sel = 4'(sel);
        rd_b_sel = 4'(15 - sel);
        #1;
        check(tag, rd_a_data, exp);
        rd_b_sel = 4'(sel);
        #1;
        check(tag, rd_b_data, exp);
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic logic cond_ok(input logic [2:0] f, input logic [3:0] c);
        logic ok = 1'b1;
        for (int b = 0; b < 3; b++)
            if (c[b] && (f[b] != c[3])) ok = 1'b0;
        return ok;
    endfunction

    // one set-and-branch; optional simultaneous port write
    task automatic sb_op(input string tag, input logic [3:0] c, input int dest,
                         input logic [15:0] off, input logic exp_tk,
                         input logic [31:0] exp_npc,
                         input logic pw, input int psel, input logic [31:0] pdat);
        @(negedge clk);
        sb_valid = 1'b1; sb_cond = c; sb_dest = 4'(dest); sb_offset = off;
        wr_en = pw; wr_sel = 4'(psel); wr_data = pdat;
        #1;
        check({tag, " R4 taken"}, 32'(sb_taken), 32'(exp_tk));
        check({tag, " R6 next_pc"}, sb_next_pc, exp_npc);
        @(posedge clk); #1;
        sb_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) begin
            if (i == 1)       read_chk("R1 reset one", i, 32'h1);
            else if (i == 13) read_chk("R2 reset flags", i, 32'h8000_0000);
            else              read_chk("R11 reset zero", i, 32'h0);
        end
    endtask

    task automatic t_write_read;
        for (int i = 2; i < 16; i++) wr(i, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101));
        for (int i = 2; i < 16; i++) begin
            if (i == 13) read_chk("R3 flags write", i, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101) | 32'h8000_0000);
            else         read_chk("R3 write read", i, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101));
        end
    endtask

    task automatic t_const_ignored;
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'h1234_5678);
        read_chk("R1 zero write ignored", 0, 32'h0);
        read_chk("R1 one write ignored", 1, 32'h1);
    endtask

    task automatic t_flag_force;
        wr(13, 32'h0000_00FF);
        read_chk("R2 bit31 forced", 13, 32'h8000_00FF);
        wr(13, 32'h7FFF_FFFF);
        read_chk("R2 bit31 forced all", 13, 32'hFFFF_FFFF);
    endtask

    task automatic t_idle;
        wr(15, 32'h0000_2000);
        @(negedge clk);
        sb_valid = 1'b0; sb_cond = 4'b1100; sb_offset = 16'h0040; sb_dest = 4'd6;
        #1;
        check("R10 idle taken", 32'(sb_taken), 32'h0);
        check("R10 idle next_pc", sb_next_pc, 32'h0000_2000);
        wr(6, 32'h0000_0077);
        read_chk("R10 idle pc kept", 15, 32'h0000_2000);
        read_chk("R10 idle dest kept", 6, 32'h0000_0077);
    endtask

    task automatic t_sweep;
        for (int f = 0; f < 4; f++) begin
            logic [2:0] fl = {1'b1, 2'(f)};
            wr(13, {1'b0, 2'(f), 29'h3C});
            for (int c = 0; c < 16; c++) begin
                logic ok = cond_ok(fl, 4'(c));
                wr(15, 32'h0000_1000);
                wr(5, 32'h0000_00AA);
                sb_op("R4 sweep", 4'(c), 5, 16'hFFF8, ok,
                      ok ? 32'h0000_0FF8 : 32'h0000_1000, 1'b0, 0, 32'h0);
                read_chk("R5 sweep dest", 5, ok ? 32'h1 : 32'h0);
                read_chk("R6 sweep pc", 15, ok ? 32'h0000_0FF8 : 32'h0000_1000);
            end
        end
    endtask

    task automatic t_always_never;
        wr(13, 32'h0);
        wr(15, 32'h0000_0100);
        sb_op("R4 always 1100", 4'b1100, 4, 16'h0010, 1'b1, 32'h0000_0110, 1'b0, 0, 0);
        sb_op("R4 never 0100", 4'b0100, 4, 16'h0010, 1'b0, 32'h0000_0110, 1'b0, 0, 0);
        read_chk("R5 never dest zero", 4, 32'h0);
    endtask

    task automatic t_pure;
        wr(15, 32'h0000_4000);
        sb_op("R7 pure branch", 4'b1100, 0, 16'h0100, 1'b1, 32'h0000_4100, 1'b0, 0, 0);
        read_chk("R7 dest0 still zero", 0, 32'h0);
        sb_op("R7 pure branch r1", 4'b1100, 1, 16'h0004, 1'b1, 32'h0000_4104, 1'b0, 0, 0);
        read_chk("R7 dest1 still one", 1, 32'h1);
        sb_op("R7 pure set", 4'b1100, 9, 16'h0000, 1'b1, 32'h0000_4104, 1'b0, 0, 0);
        read_chk("R7 pure set dest", 9, 32'h1);
        read_chk("R7 pure set pc", 15, 32'h0000_4104);
    endtask

    task automatic t_conflicts;
        wr(15, 32'h0000_8000);
        sb_op("R8 pc clash", 4'b1100, 0, 16'h0020, 1'b1, 32'h0000_8020, 1'b1, 15, 32'hDEAD_BEEF);
        read_chk("R8 pc branch wins", 15, 32'h0000_8020);
        sb_op("R8 dest clash", 4'b0100, 7, 16'h0000, 1'b0, 32'h0000_8020, 1'b1, 7, 32'h5555_5555);
        read_chk("R8 dest sb wins", 7, 32'h0);
        sb_op("R8 other write", 4'b1100, 7, 16'h0000, 1'b1, 32'h0000_8020, 1'b1, 8, 32'h3333_3333);
        read_chk("R8 other entry written", 8, 32'h3333_3333);
        read_chk("R8 dest set", 7, 32'h1);
        sb_op("R9 dest pc", 4'b1100, 15, 16'h0008, 1'b1, 32'h0000_8028, 1'b0, 0, 0);
        read_chk("R9 pc wins over dest", 15, 32'h0000_8028);
        sb_op("R9 dest pc not taken", 4'b0111, 15, 16'h0008, 1'b0, 32'h0000_8028, 1'b0, 0, 0);
        read_chk("R9 pc kept not taken", 15, 32'h0000_8028);
    endtask

    task automatic t_offsets;
        wr(15, 32'h0001_0000);
        sb_op("R6 max positive", 4'b1100, 3, 16'h7FFF, 1'b1, 32'h0001_7FFF, 1'b0, 0, 0);
        sb_op("R6 min negative", 4'b1100, 3, 16'h8000, 1'b1, 32'h0000_FFFF, 1'b0, 0, 0);
        read_chk("R6 borrow into upper half", 15, 32'h0000_FFFF);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #20;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_const_ignored();
        t_flag_force();
        t_idle();
        t_sweep();
        t_always_never();
        t_pure();
        t_conflicts();
        t_offsets();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule